// File: doc/BRIEF.md
# Edge-Triggered Three-State Phase-Frequency Comparator

This block compares a reference signal against a feedback (comparator) signal and tells a loop filter which way to steer an oscillator. It reacts only to rising transitions. If the reference rises first, the block asserts an "up" request. If the feedback rises first, it asserts a "down" request. When the opposite input then rises, the request is withdrawn. Falling transitions only update the block's record of the input levels, so neither input's duty cycle has any effect on the result.

When the reference runs faster than the feedback, "up" stays asserted continuously, and the reverse case holds "down" continuously. At equal frequency, the active request lasts for exactly the phase difference between the two inputs. When neither request is active, the charge output is treated as high impedance. An aligned flag is then raised, and a lock detector downstream can use that flag.

Both inputs are sampled on a fast system clock through a two-flop synchronizer. The comparator state combines a steering mode (idle, up or down) with the last seen level of each input, which gives twelve states. If both inputs change in the same clock cycle, the reference edge is applied first and the feedback edge second.

Top module: `pfd_tristate_cmp`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle mode with both recorded levels low: up_o=0, dn_o=0, hiz_o=1, aligned_o=1.
- R2: A rising edge on sig_in while idle asserts up_o. A rising edge on cmp_in while idle asserts dn_o.
- R3: A rising edge on cmp_in while up_o is asserted returns the block to idle. A rising edge on sig_in while dn_o is asserted returns the block to idle.
- R4: Another rising edge on the same input keeps the current request asserted, so a faster sig_in holds up_o and a faster cmp_in holds dn_o.
- R5: Falling edges on either input never change up_o, dn_o or aligned_o.
- R6: Exactly one of up_o, dn_o and hiz_o is high at all times. hiz_o is high exactly when neither request is active.
- R7: aligned_o is high exactly in the idle mode, that is, when hiz_o is high.
- R8: When both inputs change in the same clock cycle, the sig_in edge is applied before the cmp_in edge. With both rising: from up the result is idle, and from down the result is down.
- R9: An input edge reaches the outputs exactly SYNC_STAGES+1 clock cycles after it is driven (3 cycles by default), and not earlier.
- R10: At equal frequency, the request pulse lasts exactly as many clock cycles as separate the two rising edges. The pulse is up_o when sig_in leads and dn_o when sig_in lags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Reference signal input, asynchronous |
| cmp_in | input | 1 | Feedback comparator input, asynchronous |
| up_o | output | 1 | Request to raise the oscillator frequency |
| dn_o | output | 1 | Request to lower the oscillator frequency |
| hiz_o | output | 1 | Charge output is high impedance (no request) |
| aligned_o | output | 1 | Phase-pulses flag: inputs aligned, idle mode |

## Verification
The bench targets input edges that arrive in the same clock cycle from the up and down modes. A design that applied the feedback edge first would end in up instead of idle, or in idle instead of down. The bench also repeats rising edges on one input to show that the request persists; a plain toggle would drop the request on the second edge. It interleaves falling edges, which a design that reacted to both edge polarities would wrongly count as comparisons. Finally, it measures the exact latency and pulse widths in clock cycles, so an extra or missing pipeline stage would show up as a pulse that is shifted or the wrong length.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_UP   = 2'd1,
        M_DN   = 2'd2
    } steer_mode_e;

    // One of twelve comparator states: steering mode plus recorded input levels
    typedef struct packed {
        steer_mode_e mode;
        logic        sig_lvl;
        logic        cmp_lvl;
    } pc_state_t;

    localparam pc_state_t PC_RESET = '{mode: M_IDLE, sig_lvl: 1'b0, cmp_lvl: 1'b0};

    // Apply the reference input's new level
    function automatic pc_state_t apply_sig(input pc_state_t st, input logic lvl);
        pc_state_t r;
        r = st;
        if (lvl && !st.sig_lvl) begin
            r.mode = (st.mode == M_DN) ? M_IDLE : M_UP;
        end
        r.sig_lvl = lvl;
        return r;
    endfunction

    // Apply the feedback input's new level
    function automatic pc_state_t apply_cmp(input pc_state_t st, input logic lvl);
        pc_state_t r;
        r = st;
        if (lvl && !st.cmp_lvl) begin
            r.mode = (st.mode == M_UP) ? M_IDLE : M_DN;
        end
        r.cmp_lvl = lvl;
        return r;
    endfunction

endpackage

// File: rtl/pfd_sync.sv
`timescale 1ns/1ps
module pfd_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfd_fsm.sv
`timescale 1ns/1ps
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_s,
    input  logic      cmp_s,
    output pc_state_t st
);
    pc_state_t mid, nxt;

    // Reference edge first, feedback edge second (R8)
    always_comb begin
        mid = apply_sig(st, sig_s);
        nxt = apply_cmp(mid, cmp_s);
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PC_RESET;
        else     st <= nxt;
    end

    logic sig_rise, cmp_rise, any_rise;
    assign sig_rise = sig_s && !st.sig_lvl;
    assign cmp_rise = cmp_s && !st.cmp_lvl;
    assign any_rise = sig_rise || cmp_rise;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (st.mode == M_IDLE && !st.sig_lvl && !st.cmp_lvl));

    a_r2_sig_starts_up: assert property (@(posedge clk) disable iff (rst)
        (st.mode == M_IDLE && sig_rise && !cmp_rise) |=> st.mode == M_UP);

    a_r2_cmp_starts_dn: assert property (@(posedge clk) disable iff (rst)
        (st.mode == M_IDLE && cmp_rise && !sig_rise) |=> st.mode == M_DN);

    a_r3_cmp_ends_up: assert property (@(posedge clk) disable iff (rst)
        (st.mode == M_UP && cmp_rise && !sig_rise) |=> st.mode == M_IDLE);

    a_r4_up_holds: assert property (@(posedge clk) disable iff (rst)
        (st.mode == M_UP && sig_rise && !cmp_rise) |=> st.mode == M_UP);

    a_r5_fall_no_effect: assert property (@(posedge clk) disable iff (rst)
        !any_rise |=> $stable(st.mode));

    a_r8_both_from_dn: assert property (@(posedge clk) disable iff (rst)
        (st.mode == M_DN && sig_rise && cmp_rise) |=> st.mode == M_DN);
endmodule

// File: rtl/pfd_outdec.sv
`timescale 1ns/1ps
module pfd_outdec
    import pfd_pkg::*;
(
    input  pc_state_t st,
    output logic      up,
    output logic      dn,
    output logic      hiz,
    output logic      aligned
);
    always_comb begin
        up      = (st.mode == M_UP);
        dn      = (st.mode == M_DN);
        hiz     = (st.mode != M_UP) && (st.mode != M_DN);
        aligned = (st.mode == M_IDLE);
    end
endmodule

// File: rtl/pfd_tristate_cmp.sv
`timescale 1ns/1ps
module pfd_tristate_cmp
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic cmp_in,
    output logic up_o,
    output logic dn_o,
    output logic hiz_o,
    output logic aligned_o
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in, sync_out;
    pc_state_t         cur;

    assign raw_in = {sig_in, cmp_in};

    pfd_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_IN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    pfd_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sig_s (sync_out[1]),
        .cmp_s (sync_out[0]),
        .st    (cur)
    );

    pfd_outdec u_dec (
        .st      (cur),
        .up      (up_o),
        .dn      (dn_o),
        .hiz     (hiz_o),
        .aligned (aligned_o)
    );

    a_r6_one_of_three: assert property (@(posedge clk) disable iff (rst)
        $onehot({up_o, dn_o, hiz_o}));

    a_r7_flag_when_idle: assert property (@(posedge clk) disable iff (rst)
        aligned_o == hiz_o);

    a_r5_flag_stable_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!up_o && !dn_o && !$rose(up_o) && $stable(sync_out) && !rst) |=> aligned_o);
endmodule

// File: tb/sim_pfd_tristate_cmp.sv
`timescale 1ns/1ps
module sim_pfd_tristate_cmp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig = 1'b0;
    logic cmp = 1'b0;
    logic up_o, dn_o, hiz_o, aligned_o;
    int   checks = 0;
    int   errors = 0;

    always #5 clk = ~clk;

    pfd_tristate_cmp u0 (
        .clk(clk), .rst(rst), .sig_in(sig), .cmp_in(cmp),
        .up_o(up_o), .dn_o(dn_o), .hiz_o(hiz_o), .aligned_o(aligned_o)
    );

    // {sig, cmp, exp_up, exp_dn, exp_aligned}
    localparam logic [4:0] VEC [20] = '{
        5'b10_100, 5'b11_001, 5'b01_001, 5'b00_001,
        5'b01_010, 5'b11_001, 5'b10_001, 5'b00_001,
        5'b10_100, 5'b00_100, 5'b10_100, 5'b00_100,
        5'b01_001, 5'b00_001, 5'b01_010, 5'b00_010,
        5'b01_010, 5'b00_010, 5'b10_001, 5'b00_001
    };

    task automatic check_out(input string tag, input logic eu, input logic ed, input logic ea);
        checks++;
        if (up_o !== eu || dn_o !== ed || aligned_o !== ea || hiz_o !== !(eu || ed)) begin
            errors++;
            $display("FAIL %s: got up=%b dn=%b hiz=%b al=%b expected up=%b dn=%b hiz=%b al=%b",
                     tag, up_o, dn_o, hiz_o, aligned_o, eu, ed, !(eu || ed), ea);
        end
    endtask

    // drive at a falling edge, let the 3-cycle pipeline pass, sample at the next falling edge
    task automatic drive_wait(input logic s, input logic c);
        @(negedge clk);
        sig = s;
        cmp = c;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_width(input int gap, input logic sig_first, output int n_up, output int n_dn);
        n_up = 0;
        n_dn = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n_up += int'(up_o);
            n_dn += int'(dn_o);
            if (i == 0)   begin if (sig_first) sig = 1'b1; else cmp = 1'b1; end
            if (i == gap) begin if (sig_first) cmp = 1'b1; else sig = 1'b1; end
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nu, nd;
        // R1: reset with inputs high still shows idle
        sig = 1'b1; cmp = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_out("R1 reset state", 1'b0, 1'b0, 1'b1);
        sig = 1'b0; cmp = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        drive_wait(1'b0, 1'b0);
        check_out("R1 after reset release", 1'b0, 1'b0, 1'b1);

        // vector table (R2 R3 R4 R5 R6 R7)
        for (int k = 0; k < 20; k++) begin
            drive_wait(VEC[k][4], VEC[k][3]);
            check_out($sformatf("vector %0d (R2 R3 R4 R5 R6 R7)", k), VEC[k][2], VEC[k][1], VEC[k][0]);
        end

        // R9: latency is exactly three cycles
        @(negedge clk);
        sig = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_out("R9 no change after two cycles", 1'b0, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_out("R9 change after three cycles", 1'b1, 1'b0, 1'b0);
        drive_wait(1'b0, 1'b0);
        drive_wait(1'b0, 1'b1);
        check_out("R3 back to idle", 1'b0, 1'b0, 1'b1);
        drive_wait(1'b0, 1'b0);

        // R10: leading reference gives a 5-cycle up pulse
        pulse_width(5, 1'b1, nu, nd);
        checks++;
        if (nu != 5 || nd != 0) begin
            errors++;
            $display("FAIL R10 lead: got up=%0d dn=%0d expected up=5 dn=0", nu, nd);
        end
        drive_wait(1'b0, 1'b0);
        check_out("R10 idle after lead", 1'b0, 1'b0, 1'b1);

        // R10: lagging reference gives a 7-cycle down pulse
        pulse_width(7, 1'b0, nu, nd);
        checks++;
        if (nu != 0 || nd != 7) begin
            errors++;
            $display("FAIL R10 lag: got up=%0d dn=%0d expected up=0 dn=7", nu, nd);
        end
        drive_wait(1'b0, 1'b0);

        // R8: simultaneous rises from up -> idle
        drive_wait(1'b1, 1'b0);
        drive_wait(1'b0, 1'b0);
        check_out("R8 setup up", 1'b1, 1'b0, 1'b0);
        drive_wait(1'b1, 1'b1);
        check_out("R8 both rise from up", 1'b0, 1'b0, 1'b1);
        drive_wait(1'b0, 1'b0);

        // R8: simultaneous rises from down -> down
        drive_wait(1'b0, 1'b1);
        drive_wait(1'b0, 1'b0);
        check_out("R8 setup down", 1'b0, 1'b1, 1'b0);
        drive_wait(1'b1, 1'b1);
        check_out("R8 both rise from down", 1'b0, 1'b1, 1'b0);
        // R5: both falling together keeps down
        drive_wait(1'b0, 1'b0);
        check_out("R5 simultaneous fall", 1'b0, 1'b1, 1'b0);

        // R1: mid-run reset returns to idle
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out("R1 mid-run reset", 1'b0, 1'b0, 1'b1);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule